// File: doc/BRIEF.md
# Parity-Protected Remappable SRAM Controller

This block sits between a simple single-beat 32-bit bus and four on-chip SRAM banks: two instruction banks and two data banks. The banks are modelled as behavioural arrays inside the block. A control register picks one of two layouts. In the split layout the instruction banks form one window and each data bank has its own window. In the all-data layout the instruction banks are folded into the two data windows, so the whole store is reachable as data. When the cache bit is set, the top quarter of the second instruction bank belongs to a cache and the bus cannot reach it.

Every stored word carries two even-parity bits, one for each 16-bit half. A byte or half-word write merges its bytes into the stored word. It then recomputes parity only for the halves it touches. On reads, parity is checked when checking is enabled for the region the address falls in. A mismatch gives a one-cycle pulse and records the faulting address in a sticky status that is cleared by a write-one strobe.

A bank is 2^BANK_AW words, which is 16 kB at BANK_AW=12. The defaults keep elaboration small.

Top module: `par_sram_ctrl`

## Requirements
- R1: With control bit 31 set (split layout), the instruction window at IBASE spans two banks: bank 0 at offsets [0, B) and bank 1 at [B, 2B), where B = 4·2^BANK_AW bytes. Data window 0 at DBASE0 maps bank 2 at [0, B). Data window 1 at DBASE1 maps bank 3 at [0, B).
- R2: With control bit 31 clear (all-data layout), the instruction window is unmapped. Data window 0 spans [0, 2B) as bank 2 then bank 0. Data window 1 spans [0, 2B) as bank 3 then bank 1.
- R3: With control bit 30 set, the top quarter of bank 1 is rejected from whichever window maps it. Reads there return an error, and writes there leave the stored data unchanged.
- R4: An access that maps to no bank gets an error response with read data zero, and a write to it changes no storage.
- R5: Every request gets exactly one response, one cycle later, and there is no response without a request. A read issued in the cycle right after a write to the same address returns the newly written data.
- R6: Byte strobe bit n (1 = write) selects byte n (bits 8n+7:8n). Unstrobed bytes keep their stored value. Write responses carry zero data.
- R7: Parity bit 0 is the XOR of bits 15:0 and parity bit 1 is the XOR of bits 31:16. A write updates only the parity of halves with at least one strobed byte, computed over the merged half. While control bit 8 is set, written parity is inverted.
- R8: Control bits 0, 1 and 2 enable checking for the instruction window, data window 0 and data window 1. A read whose stored parity mismatches in an enabled region raises the error pulse for exactly the response cycle. Disabled regions, writes and error responses never pulse.
- R9: The pulse sets the sticky flag on the next edge. The flag holds the address of the first faulting read until the clear strobe, and a new error wins over a simultaneous clear.
- R10: The control register resets to 0x80000007, keeps only bits 31, 30, 8 and 2:0 on a write, reads back through the control output, and applies from the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_req | input | 1 | Request valid for one cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Byte address (word aligned) |
| bus_be | input | 4 | Byte strobes |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Response valid, one cycle after the request |
| bus_rdata | output | 32 | Read data |
| bus_err | output | 1 | Decode error response |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 32 | Control register write value |
| ctl_q | output | 32 | Control register contents |
| perr_clr | input | 1 | Write-one clear for the sticky parity status |
| perr_pulse | output | 1 | Parity error in this response cycle |
| perr_sticky | output | 1 | Sticky parity error flag |
| perr_addr | output | 32 | Address of the first faulting read |

## Verification
The bench builds the controller with BANK_AW=4, so each bank holds sixteen words and a window at most 128 bytes. At that size every word of every window can be written and read back in both layouts, with and without the cache carve-out. The aliasing between the split and all-data layouts is therefore checked word by word against an arithmetic address model. Parity is driven to a mismatch through the inversion bit. The bench keeps its own record of which halves are corrupt, so per-half repair by narrow writes, the region enables and the sticky status can all be predicted.

// File: rtl/sramc_pkg.sv
package sramc_pkg;

  localparam int NBANK = 4;

  localparam int CTL_IRAM_BIT  = 31;
  localparam int CTL_CACHE_BIT = 30;
  localparam int CTL_INJ_BIT   = 8;

  localparam logic [31:0] CTL_RESET = 32'h8000_0007;
  localparam logic [31:0] CTL_MASK  = 32'hC000_0107;

  typedef enum logic [1:0] {
    RGN_INSTR = 2'd0,
    RGN_DWIN0 = 2'd1,
    RGN_DWIN1 = 2'd2,
    RGN_NONE  = 2'd3
  } region_e;

  typedef struct packed {
    logic    hit;
    logic [1:0] bank;
    region_e region;
  } dec_t;

  // even parity per 16-bit half: {upper, lower}
  function automatic logic [1:0] word_par(input logic [31:0] w);
    return {^w[31:16], ^w[15:0]};
  endfunction

  function automatic logic [31:0] byte_merge(input logic [31:0] old_w,
                                             input logic [31:0] new_w,
                                             input logic [3:0]  be);
    logic [31:0] r;
    for (int b = 0; b < 4; b++)
      r[8*b +: 8] = be[b] ? new_w[8*b +: 8] : old_w[8*b +: 8];
    return r;
  endfunction

endpackage

// File: rtl/sramc_decode.sv
module sramc_decode
  import sramc_pkg::*;
#(
  parameter int unsigned BANK_AW = 8,
  parameter logic [31:0] IBASE   = 32'h1000_0000,
  parameter logic [31:0] DBASE0  = 32'h2000_0000,
  parameter logic [31:0] DBASE1  = 32'h2004_0000
) (
  input  logic [31:0]        addr,
  input  logic               iram_en,
  input  logic               cache_en,
  output dec_t               dec,
  output logic [BANK_AW-1:0] word,
  output logic               carve_hit
);

  localparam int unsigned WB = BANK_AW + 3;  // window span 2B = 2^WB bytes

  logic upper_half;
  logic top_quarter;
  logic in_i, in_d0, in_d1;
  logic unused_lsb;

  assign upper_half  = addr[WB-1];
  assign word        = addr[WB-2:2];
  assign top_quarter = &word[BANK_AW-1:BANK_AW-2];
  assign in_i        = (addr[31:WB] == IBASE[31:WB]);
  assign in_d0       = (addr[31:WB] == DBASE0[31:WB]);
  assign in_d1       = (addr[31:WB] == DBASE1[31:WB]);
  assign unused_lsb  = ^addr[1:0];

  always_comb begin
    dec       = '{hit: 1'b0, bank: 2'd0, region: RGN_NONE};
    carve_hit = 1'b0;
    if (in_i && iram_en) begin
      dec.hit    = 1'b1;
      dec.bank   = {1'b0, upper_half};
      dec.region = RGN_INSTR;
      carve_hit  = cache_en && upper_half && top_quarter;
    end else if (in_d0) begin
      dec.region = RGN_DWIN0;
      if (!upper_half) begin
        dec.hit  = 1'b1;
        dec.bank = 2'd2;
      end else if (!iram_en) begin
        dec.hit  = 1'b1;
        dec.bank = 2'd0;
      end
    end else if (in_d1) begin
      dec.region = RGN_DWIN1;
      if (!upper_half) begin
        dec.hit  = 1'b1;
        dec.bank = 2'd3;
      end else if (!iram_en) begin
        dec.hit   = 1'b1;
        dec.bank  = 2'd1;
        carve_hit = cache_en && top_quarter;
      end
    end
    if (carve_hit) dec.hit = 1'b0;
  end

endmodule

// File: rtl/sramc_bank.sv
module sramc_bank
  import sramc_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input  logic          clk,
  input  logic          sel,
  input  logic          we,
  input  logic          inj,
  input  logic [3:0]    be,
  input  logic [31:0]   wdata,
  input  logic [AW-1:0] idx,
  output logic [31:0]   rd_word,
  output logic [1:0]    rd_par
);

  localparam int unsigned DEPTH = 1 << AW;

  // {parity[1:0], data[31:0]}
  logic [33:0] mem [DEPTH];

  logic [33:0] old_e;
  logic [31:0] merged;
  logic [1:0]  half_touch;
  logic [1:0]  fresh_par;
  logic [1:0]  new_par;

  assign old_e      = mem[idx];
  assign merged     = byte_merge(old_e[31:0], wdata, be);
  assign half_touch = {be[3] | be[2], be[1] | be[0]};
  assign fresh_par  = word_par(merged) ^ {2{inj}};
  assign new_par[0] = half_touch[0] ? fresh_par[0] : old_e[32];
  assign new_par[1] = half_touch[1] ? fresh_par[1] : old_e[33];

  always_ff @(posedge clk) begin
    if (sel && we) mem[idx] <= {new_par, merged};
    if (sel && !we) begin
      rd_word <= old_e[31:0];
      rd_par  <= old_e[33:32];
    end
  end

endmodule

// File: rtl/sramc_pcheck.sv
module sramc_pcheck
  import sramc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rsp_valid,
  input  logic        rsp_we,
  input  logic        rsp_err,
  input  logic        chk_en,
  input  logic [31:0] rd_word,
  input  logic [1:0]  rd_par,
  input  logic [31:0] rsp_addr,
  input  logic        clr,
  output logic        pulse,
  output logic        sticky,
  output logic [31:0] flt_addr
);

  logic mismatch;

  assign mismatch = (word_par(rd_word) != rd_par);
  assign pulse    = rsp_valid && !rsp_we && !rsp_err && chk_en && mismatch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sticky   <= 1'b0;
      flt_addr <= '0;
    end else if (pulse) begin
      if (!sticky || clr) flt_addr <= rsp_addr;
      sticky <= 1'b1;
    end else if (clr) begin
      sticky <= 1'b0;
    end
  end

  AST_PULSE_SETS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> sticky);  // R9

  AST_FIRST_ADDR_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (sticky && !clr) |=> (sticky && $stable(flt_addr)));  // R9

  AST_PULSE_CLEAN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |-> (rsp_valid && !rsp_we && !rsp_err));  // R8

endmodule

// File: rtl/par_sram_ctrl.sv
module par_sram_ctrl
  import sramc_pkg::*;
#(
  parameter int unsigned BANK_AW = 8,
  parameter logic [31:0] IBASE   = 32'h1000_0000,
  parameter logic [31:0] DBASE0  = 32'h2000_0000,
  parameter logic [31:0] DBASE1  = 32'h2004_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_req,
  input  logic        bus_we,
  input  logic [31:0] bus_addr,
  input  logic [3:0]  bus_be,
  input  logic [31:0] bus_wdata,
  output logic        bus_rvalid,
  output logic [31:0] bus_rdata,
  output logic        bus_err,
  input  logic        ctl_we,
  input  logic [31:0] ctl_wdata,
  output logic [31:0] ctl_q,
  input  logic        perr_clr,
  output logic        perr_pulse,
  output logic        perr_sticky,
  output logic [31:0] perr_addr
);

  // control register
  logic [31:0] ctl_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_r <= CTL_RESET;
    else if (ctl_we) ctl_r <= ctl_wdata & CTL_MASK;
  end

  assign ctl_q = ctl_r;

  // decode
  dec_t               dec;
  logic [BANK_AW-1:0] word_idx;
  logic               carve_hit;
  logic               req_hit;

  sramc_decode #(
    .BANK_AW (BANK_AW),
    .IBASE   (IBASE),
    .DBASE0  (DBASE0),
    .DBASE1  (DBASE1)
  ) u_decode (
    .addr      (bus_addr),
    .iram_en   (ctl_r[CTL_IRAM_BIT]),
    .cache_en  (ctl_r[CTL_CACHE_BIT]),
    .dec       (dec),
    .word      (word_idx),
    .carve_hit (carve_hit)
  );

  assign req_hit = bus_req && dec.hit;

  // banks
  logic [31:0] bank_word [NBANK];
  logic [1:0]  bank_par  [NBANK];

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    sramc_bank #(.AW(BANK_AW)) u_bank (
      .clk     (clk),
      .sel     (req_hit && (dec.bank == 2'(g))),
      .we      (bus_we),
      .inj     (ctl_r[CTL_INJ_BIT]),
      .be      (bus_be),
      .wdata   (bus_wdata),
      .idx     (word_idx),
      .rd_word (bank_word[g]),
      .rd_par  (bank_par[g])
    );
  end

  // response stage
  logic        rsp_valid;
  logic        rsp_we;
  logic        rsp_err;
  logic [1:0]  rsp_bank;
  region_e     rsp_region;
  logic [31:0] rsp_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_we     <= 1'b0;
      rsp_err    <= 1'b0;
      rsp_bank   <= '0;
      rsp_region <= RGN_NONE;
      rsp_addr   <= '0;
    end else begin
      rsp_valid <= bus_req;
      if (bus_req) begin
        rsp_we     <= bus_we;
        rsp_err    <= !dec.hit;
        rsp_bank   <= dec.bank;
        rsp_region <= dec.region;
        rsp_addr   <= bus_addr;
      end
    end
  end

  logic [31:0] sel_word;
  logic [1:0]  sel_par;
  logic        chk_en;

  assign sel_word = bank_word[rsp_bank];
  assign sel_par  = bank_par[rsp_bank];

  always_comb begin
    unique case (rsp_region)
      RGN_INSTR: chk_en = ctl_r[0];
      RGN_DWIN0: chk_en = ctl_r[1];
      RGN_DWIN1: chk_en = ctl_r[2];
      default:   chk_en = 1'b0;
    endcase
  end

  assign bus_rvalid = rsp_valid;
  assign bus_err    = rsp_valid && rsp_err;
  assign bus_rdata  = (rsp_valid && !rsp_we && !rsp_err) ? sel_word : '0;

  sramc_pcheck u_pcheck (
    .clk       (clk),
    .rst_n     (rst_n),
    .rsp_valid (rsp_valid),
    .rsp_we    (rsp_we),
    .rsp_err   (rsp_err),
    .chk_en    (chk_en),
    .rd_word   (sel_word),
    .rd_par    (sel_par),
    .rsp_addr  (rsp_addr),
    .clr       (perr_clr),
    .pulse     (perr_pulse),
    .sticky    (perr_sticky),
    .flt_addr  (perr_addr)
  );

  AST_RESP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |=> bus_rvalid);  // R5

  AST_IDLE_NO_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_req |=> !bus_rvalid);  // R5

  AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> (bus_rvalid && bus_rdata == 32'd0));  // R4

  AST_CARVE_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && carve_hit) |=> bus_err);  // R3

endmodule

// File: tb/test_par_sram_ctrl.sv
`timescale 1ns/100ps
module test_par_sram_ctrl;

  localparam logic [31:0] IB = 32'h1000_0000;
  localparam logic [31:0] D0 = 32'h2000_0000;
  localparam logic [31:0] D1 = 32'h2004_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0, bus_we = 1'b0;
  logic [31:0] bus_addr = '0, bus_wdata = '0;
  logic [3:0]  bus_be = '0;
  logic        bus_rvalid, bus_err;
  logic [31:0] bus_rdata;
  logic        ctl_we = 1'b0;
  logic [31:0] ctl_wdata = '0;
  logic [31:0] ctl_q;
  logic        perr_clr = 1'b0;
  logic        perr_pulse, perr_sticky;
  logic [31:0] perr_addr;

  always #2.5 clk = ~clk;

  par_sram_ctrl #(.BANK_AW(4)) i_par_sram_ctrl (
    .clk, .rst_n, .bus_req, .bus_we, .bus_addr, .bus_be, .bus_wdata,
    .bus_rvalid, .bus_rdata, .bus_err, .ctl_we, .ctl_wdata, .ctl_q,
    .perr_clr, .perr_pulse, .perr_sticky, .perr_addr
  );

  int n_tests = 0;
  int n_fail  = 0;
  logic [31:0] cur_ctl = 32'h8000_0007;
  logic [31:0] mdata [64];
  bit   [1:0]  mbad  [64];

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_0000;
  endfunction

  // model index: 0..15 bank0, 16..31 bank1, 32..47 bank2, 48..63 bank3
  function automatic int phys(input logic [31:0] a, input bit iram, input bit cache);
    int o;
    if (iram && a >= IB && a < IB + 128) begin
      o = int'((a - IB) / 4);
      if (cache && o >= 28) return -1;
      return o;
    end
    if (a >= D0 && a < D0 + (iram ? 64 : 128)) begin
      o = int'((a - D0) / 4);
      return (o < 16) ? 32 + o : o - 16;
    end
    if (a >= D1 && a < D1 + (iram ? 64 : 128)) begin
      o = int'((a - D1) / 4);
      if (o < 16) return 48 + o;
      if (cache && o >= 28) return -1;
      return o;
    end
    return -1;
  endfunction

  function automatic int rgn(input logic [31:0] a);
    if (a >= IB && a < IB + 128) return 0;
    if (a >= D0 && a < D0 + 128) return 1;
    return 2;
  endfunction

  task automatic acc(input bit we, input logic [31:0] a, input logic [3:0] be,
                     input logic [31:0] wd, input string rq);
    int idx;
    bit eerr, epl;
    logic [31:0] erd;
    @(negedge clk);
    bus_req = 1'b1; bus_we = we; bus_addr = a; bus_be = be; bus_wdata = wd;
    @(negedge clk);
    bus_req = 1'b0;
    idx  = phys(a, cur_ctl[31], cur_ctl[30]);
    eerr = (idx < 0);
    erd  = '0;
    epl  = 1'b0;
    if (!eerr) begin
      if (we) begin
        for (int b = 0; b < 4; b++) if (be[b]) mdata[idx][8*b +: 8] = wd[8*b +: 8];
        if (be[0] | be[1]) mbad[idx][0] = cur_ctl[8];
        if (be[2] | be[3]) mbad[idx][1] = cur_ctl[8];
      end else begin
        erd = mdata[idx];
        epl = cur_ctl[rgn(a)] && (mbad[idx] != 2'b00);
      end
    end
    check(bus_rvalid == 1'b1, rq, "rvalid", 32'(bus_rvalid), 32'd1);
    check(bus_err == eerr, rq, "err", 32'(bus_err), 32'(eerr));
    check(bus_rdata == erd, rq, "rdata", bus_rdata, erd);
    check(perr_pulse == epl, rq, "perr_pulse", 32'(perr_pulse), 32'(epl));
  endtask

  task automatic setctl(input logic [31:0] v);
    @(negedge clk);
    ctl_we = 1'b1; ctl_wdata = v;
    @(negedge clk);
    ctl_we = 1'b0;
    cur_ctl = v & 32'hC000_0107;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) begin mdata[i] = '0; mbad[i] = 2'b00; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state (R10, R5)
    check(ctl_q == 32'h8000_0007, "R10", "ctl reset", ctl_q, 32'h8000_0007);
    check(bus_rvalid == 1'b0, "R5", "idle rvalid", 32'(bus_rvalid), 32'd0);
    check(perr_sticky == 1'b0, "R9", "sticky reset", 32'(perr_sticky), 32'd0);

    // R10: write mask
    setctl(32'hFFFF_FFFF);
    check(ctl_q == 32'hC000_0107, "R10", "ctl mask", ctl_q, 32'hC000_0107);
    setctl(32'h8000_0007);

    // R1: split layout full sweep
    for (int o = 0; o < 32; o++) acc(1'b1, IB + 32'(4*o), 4'hF, pat(IB + 32'(4*o)), "R1");
    for (int o = 0; o < 16; o++) acc(1'b1, D0 + 32'(4*o), 4'hF, pat(D0 + 32'(4*o)), "R1");
    for (int o = 0; o < 16; o++) acc(1'b1, D1 + 32'(4*o), 4'hF, pat(D1 + 32'(4*o)), "R1");
    for (int o = 0; o < 32; o++) acc(1'b0, IB + 32'(4*o), 4'hF, 32'd0, "R1");
    for (int o = 0; o < 16; o++) acc(1'b0, D0 + 32'(4*o), 4'hF, 32'd0, "R1");
    for (int o = 0; o < 16; o++) acc(1'b0, D1 + 32'(4*o), 4'hF, 32'd0, "R1");

    // R4: unmapped reads and writes
    acc(1'b1, D0 + 32'd64, 4'hF, 32'hDEAD_BEEF, "R4");
    acc(1'b0, D0 + 32'd64, 4'hF, 32'd0, "R4");
    acc(1'b0, D1 + 32'd68, 4'hF, 32'd0, "R4");
    acc(1'b0, IB + 32'd128, 4'hF, 32'd0, "R4");
    acc(1'b0, 32'h3000_0000, 4'hF, 32'd0, "R4");

    // R6: byte and half-word strobes
    acc(1'b1, D1 + 32'd12, 4'b0001, 32'hFFFF_FFA1, "R6");
    acc(1'b0, D1 + 32'd12, 4'hF, 32'd0, "R6");
    acc(1'b1, D1 + 32'd12, 4'b0010, 32'hFFFF_B2FF, "R6");
    acc(1'b0, D1 + 32'd12, 4'hF, 32'd0, "R6");
    acc(1'b1, D1 + 32'd12, 4'b1100, 32'hC3D4_FFFF, "R6");
    acc(1'b0, D1 + 32'd12, 4'hF, 32'd0, "R6");
    acc(1'b1, D1 + 32'd12, 4'b0110, 32'h0077_8800, "R6");
    acc(1'b0, D1 + 32'd12, 4'hF, 32'd0, "R6");

    // R3: cache carve-out in split layout
    setctl(32'hC000_0007);
    for (int o = 24; o < 32; o++) acc(1'b0, IB + 32'(4*o), 4'hF, 32'd0, "R3");
    acc(1'b1, IB + 32'd116, 4'hF, 32'h0BAD_0BAD, "R3");
    setctl(32'h8000_0007);
    acc(1'b0, IB + 32'd116, 4'hF, 32'd0, "R3");

    // R5: write then read back-to-back
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = D0 + 32'd20; bus_be = 4'hF; bus_wdata = 32'hA5C3_0F96;
    @(negedge clk);
    check(bus_rvalid == 1'b1 && bus_err == 1'b0, "R5", "write resp", 32'(bus_rvalid), 32'd1);
    bus_we = 1'b0;
    @(negedge clk);
    bus_req = 1'b0;
    mdata[37] = 32'hA5C3_0F96;
    check(bus_rdata == 32'hA5C3_0F96, "R5", "b2b rdata", bus_rdata, 32'hA5C3_0F96);
    @(negedge clk);
    check(bus_rvalid == 1'b0, "R5", "no resp when idle", 32'(bus_rvalid), 32'd0);

    // R2: all-data layout aliasing, R4 in that layout
    setctl(32'h0000_0007);
    for (int o = 0; o < 32; o++) acc(1'b0, D0 + 32'(4*o), 4'hF, 32'd0, "R2");
    for (int o = 0; o < 32; o++) acc(1'b0, D1 + 32'(4*o), 4'hF, 32'd0, "R2");
    acc(1'b0, IB, 4'hF, 32'd0, "R2");
    acc(1'b1, D0 + 32'd68, 4'hF, 32'h1357_9BDF, "R2");
    acc(1'b0, D0 + 32'd68, 4'hF, 32'd0, "R2");
    // R3: carve-out in all-data layout
    setctl(32'h4000_0007);
    for (int o = 24; o < 32; o++) acc(1'b0, D1 + 32'(4*o), 4'hF, 32'd0, "R3");
    acc(1'b1, D1 + 32'd124, 4'hF, 32'h7777_7777, "R3");
    acc(1'b0, D0 + 32'd124, 4'hF, 32'd0, "R3");
    setctl(32'h0000_0007);
    acc(1'b0, D1 + 32'd124, 4'hF, 32'd0, "R3");

    // R7, R8, R9: parity
    setctl(32'h8000_0007);
    setctl(32'h8000_0107);
    acc(1'b1, D0 + 32'd8, 4'hF, 32'h1234_ABCD, "R7");
    setctl(32'h8000_0007);
    acc(1'b0, D0 + 32'd8, 4'hF, 32'd0, "R8");
    @(negedge clk);
    check(perr_sticky == 1'b1, "R9", "sticky set", 32'(perr_sticky), 32'd1);
    check(perr_addr == D0 + 32'd8, "R9", "fault addr", perr_addr, D0 + 32'd8);

    setctl(32'h8000_0107);
    acc(1'b1, IB + 32'd16, 4'b0010, 32'h0000_EE00, "R7");
    setctl(32'h8000_0007);
    acc(1'b0, IB + 32'd16, 4'hF, 32'd0, "R7");
    @(negedge clk);
    check(perr_addr == D0 + 32'd8, "R9", "first addr kept", perr_addr, D0 + 32'd8);
    acc(1'b1, IB + 32'd16, 4'b0001, 32'h0000_0011, "R7");
    acc(1'b0, IB + 32'd16, 4'hF, 32'd0, "R7");
    acc(1'b1, D0 + 32'd8, 4'b0001, 32'h0000_0042, "R7");
    acc(1'b0, D0 + 32'd8, 4'hF, 32'd0, "R7");
    acc(1'b1, D0 + 32'd8, 4'b1000, 32'h9900_0000, "R7");
    acc(1'b0, D0 + 32'd8, 4'hF, 32'd0, "R7");

    @(negedge clk); perr_clr = 1'b1;
    @(negedge clk); perr_clr = 1'b0;
    check(perr_sticky == 1'b0, "R9", "sticky cleared", 32'(perr_sticky), 32'd0);

    setctl(32'h8000_0107);
    acc(1'b1, D0 + 32'd28, 4'hF, 32'hCAFE_F00D, "R8");
    setctl(32'h8000_0005);
    acc(1'b0, D0 + 32'd28, 4'hF, 32'd0, "R8");
    acc(1'b0, D1 + 32'd28, 4'hF, 32'd0, "R8");
    @(negedge clk);
    check(perr_sticky == 1'b0, "R8", "disabled region no sticky", 32'(perr_sticky), 32'd0);
    setctl(32'h8000_0007);
    acc(1'b0, D0 + 32'd28, 4'hF, 32'd0, "R8");
    @(negedge clk);
    check(perr_sticky == 1'b1, "R9", "sticky after enable", 32'(perr_sticky), 32'd1);
    check(perr_addr == D0 + 32'd28, "R9", "new fault addr", perr_addr, D0 + 32'd28);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule